// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a queue of master transfer commands and a bit-level I2C engine. Each queued command holds one data byte, a direction bit, a stop flag and a restart flag. The sequencer turns the queue into a series of bus-condition requests for the engine: START, RESTART, STOP, write a byte and read a byte. It issues one request at a time and waits for the engine's done pulse before it issues the next.

The sequencer remembers the direction of the last byte in the current transfer. From that direction and from the flags in each command, it decides whether a repeated start must come before the byte. When repeated starts are turned off, it sends a stop and then a new start instead. A stop follows any byte whose stop flag is set. If the queue runs dry without a stop, the sequencer holds the clock low and waits for the next command.

Top module: `i2c_cmd_seq`

## Requirements
- R1: The first command after idle (after reset or after a STOP) is preceded by a START request (action code 1). Only then is its byte action issued.
- R2: When a transfer is active, the restart flag is clear and the direction bit equals that of the previous byte, the byte action is issued directly with no condition before it. Action code 4 is a write (direction bit 0) and action code 5 is a read (direction bit 1).
- R3: With `restart_en` high and a command's restart flag set, a RESTART request (action code 2) comes before the byte, even when the direction is unchanged.
- R4: With `restart_en` high and the restart flag clear, a RESTART comes before the byte only when the direction bit differs from that of the previous byte.
- R5: With `restart_en` low, every case that calls for a RESTART produces a STOP (action code 3) followed by a START instead. RESTART is never requested.
- R6: A command with its stop flag set is followed by a STOP after its byte. If more commands are queued, a START follows at once.
- R7: When a byte without a stop flag completes and the queue is empty, `scl_hold` goes high and no request is issued. The next command continues the transfer without a START. `scl_hold` is low while idle.
- R8: A write request carries the command's data byte on `eng_byte`. A read request carries zero there, whatever data the command held.
- R9: When the queue holds DEPTH commands, `cmd_full` is high and a push is ignored.
- R10: `eng_req` is a one-cycle pulse and only one request is outstanding at a time. When more work is queued, the next request is issued exactly two cycles after the done pulse is sampled.
- R11: After reset, `eng_req`, `scl_hold` and `cmd_full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_en | input | 1 | Allow repeated starts; when low, use STOP then START |
| cmd_push | input | 1 | Push one command into the queue |
| cmd_data | input | 8 | Data byte of the pushed command |
| cmd_rd | input | 1 | Direction: 1 read, 0 write |
| cmd_stop | input | 1 | Issue STOP after this byte |
| cmd_restart | input | 1 | Force a repeated start before this byte |
| cmd_full | output | 1 | Queue full; pushes are dropped |
| eng_req | output | 1 | One-cycle request to the bit engine |
| eng_act | output | 3 | Action code: 1 START, 2 RESTART, 3 STOP, 4 WRITE, 5 READ |
| eng_byte | output | 8 | Byte to send for WRITE, zero otherwise |
| eng_done | input | 1 | Engine has completed the outstanding action |
| scl_hold | output | 1 | Clock held low while waiting on an empty queue |

## Verification
A request is due two clock edges after the sampled done pulse: one edge to return the controller to its decision state and one to register the request. The bench counts negative edges from each done pulse and requires the next request on the second of them whenever expected actions are pending. The expected action stream is built in the bench at each accepted push from the command flags, and every request is compared against it as it appears, sampled at the falling edge. The clock-hold flag is checked only after the expected stream has drained and the bench has waited several more cycles, so that it is not read while it is still settling.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ACT_NONE    = 3'd0,
    ACT_START   = 3'd1,
    ACT_RESTART = 3'd2,
    ACT_STOP    = 3'd3,
    ACT_WRITE   = 3'd4,
    ACT_READ    = 3'd5
  } act_e;

  typedef struct packed {
    logic              restart;
    logic              stop;
    logic              rd;
    logic [BYTE_W-1:0] data;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);
endpackage

// File: rtl/i2c_cmd_fifo.sv
module i2c_cmd_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == DEPTH_C);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    full && push && !pop |=> full);

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C);
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_en,
  input  cmd_t              head,
  input  logic              head_vld,
  output logic              pop,
  output logic              req,
  output act_e              act,
  output logic [BYTE_W-1:0] byte_o,
  input  logic              done,
  output logic              hold
);
  typedef enum logic {S_DECIDE, S_WAIT} st_e;

  st_e  st;
  logic active, prev_rd, go_byte, stop_pend, byte_stop;
  logic issue;
  act_e nxt;

  always_comb begin
    issue = 1'b0;
    nxt   = ACT_NONE;
    if (st == S_DECIDE) begin
      if (stop_pend) begin
        issue = 1'b1;
        nxt   = ACT_STOP;
      end else if (head_vld) begin
        issue = 1'b1;
        if (go_byte)
          nxt = head.rd ? ACT_READ : ACT_WRITE;
        else if (!active)
          nxt = ACT_START;
        else if (head.restart || (head.rd != prev_rd))
          nxt = restart_en ? ACT_RESTART : ACT_STOP;
        else
          nxt = head.rd ? ACT_READ : ACT_WRITE;
      end
    end
  end

  assign pop  = (st == S_WAIT) && done && (act == ACT_WRITE || act == ACT_READ);
  assign hold = (st == S_DECIDE) && active && !head_vld && !stop_pend && !go_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_DECIDE;
      active    <= 1'b0;
      prev_rd   <= 1'b0;
      go_byte   <= 1'b0;
      stop_pend <= 1'b0;
      byte_stop <= 1'b0;
      req       <= 1'b0;
      act       <= ACT_NONE;
      byte_o    <= '0;
    end else begin
      req <= issue;
      if (issue) begin
        st     <= S_WAIT;
        act    <= nxt;
        byte_o <= (nxt == ACT_WRITE) ? head.data : '0;
        if (nxt == ACT_WRITE || nxt == ACT_READ) begin
          go_byte   <= 1'b0;
          byte_stop <= head.stop;
          prev_rd   <= head.rd;
        end
      end else if (st == S_WAIT && done) begin
        st <= S_DECIDE;
        case (act)
          ACT_START: begin
            active  <= 1'b1;
            go_byte <= 1'b1;
          end
          ACT_RESTART: go_byte <= 1'b1;
          ACT_STOP: begin
            active    <= 1'b0;
            stop_pend <= 1'b0;
            go_byte   <= 1'b0;
          end
          ACT_WRITE, ACT_READ: stop_pend <= byte_stop;
          default: ;
        endcase
      end
    end
  end

  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);

  // R8
  read_byte_zero_chk: assert property (@(posedge clk) disable iff (rst)
    req && act == ACT_READ |-> byte_o == '0);

  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> !req);

  // R5
  restart_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    req && act == ACT_RESTART |-> $past(restart_en));
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_en,
  input  logic              cmd_push,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              cmd_rd,
  input  logic              cmd_stop,
  input  logic              cmd_restart,
  output logic              cmd_full,
  output logic              eng_req,
  output logic [2:0]        eng_act,
  output logic [BYTE_W-1:0] eng_byte,
  input  logic              eng_done,
  output logic              scl_hold
);
  cmd_t             in_cmd, head;
  logic [CMD_W-1:0] head_bits;
  logic             empty, pop;
  act_e             act;

  assign in_cmd = '{restart: cmd_restart, stop: cmd_stop, rd: cmd_rd, data: cmd_data};
  assign head   = cmd_t'(head_bits);

  i2c_cmd_fifo #(.DEPTH(DEPTH), .WIDTH(CMD_W)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (cmd_push),
    .din   (in_cmd),
    .pop   (pop),
    .dout  (head_bits),
    .empty (empty),
    .full  (cmd_full)
  );

  i2c_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .restart_en (restart_en),
    .head       (head),
    .head_vld   (!empty),
    .pop        (pop),
    .req        (eng_req),
    .act        (act),
    .byte_o     (eng_byte),
    .done       (eng_done),
    .hold       (scl_hold)
  );

  assign eng_act = act;
endmodule

// File: tb/tb_i2c_cmd_seq.sv
module tb_i2c_cmd_seq;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       restart_en = 1'b1;
  logic       cmd_push = 1'b0, cmd_rd = 1'b0, cmd_stop = 1'b0, cmd_restart = 1'b0;
  logic [7:0] cmd_data = '0;
  logic       cmd_full, eng_req, eng_done = 1'b0, scl_hold;
  logic [2:0] eng_act;
  logic [7:0] eng_byte;

  always #5 clk = ~clk;

  i2c_cmd_seq #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .restart_en(restart_en),
    .cmd_push(cmd_push), .cmd_data(cmd_data), .cmd_rd(cmd_rd),
    .cmd_stop(cmd_stop), .cmd_restart(cmd_restart), .cmd_full(cmd_full),
    .eng_req(eng_req), .eng_act(eng_act), .eng_byte(eng_byte),
    .eng_done(eng_done), .scl_hold(scl_hold)
  );

  int    n_run = 0, n_fail = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    m_active = 0, m_prev = 0;
  bit    stall = 0, outstanding = 0, gap_armed = 0;
  int    since_done = 0;

  task automatic chk(bit ok, string tag, int got, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, expv);
    end
  endtask

  function automatic void want(int a, int b, string t);
    exp_q.push_back(a * 256 + b);
    tag_q.push_back(t);
  endfunction

  // Reference model: expected actions per accepted command
  function automatic void model(bit rd, bit st, bit rs, logic [7:0] d);
    if (!m_active) begin
      want(1, 0, "R1");
      m_active = 1;
    end else if (rs || rd != m_prev) begin
      if (restart_en) want(2, 0, rs ? "R3" : "R4");
      else begin
        want(3, 0, "R5");
        want(1, 0, "R5");
      end
    end
    if (rd) want(5, 0, "R8");
    else    want(4, d, "R2");
    m_prev = rd;
    if (st) begin
      want(3, 0, "R6");
      m_active = 0;
    end
  endfunction

  task automatic push(bit rd, bit st, bit rs, logic [7:0] d);
    bit acc;
    @(posedge clk); #1;
    cmd_push = 1; cmd_rd = rd; cmd_stop = st; cmd_restart = rs; cmd_data = d;
    acc = !cmd_full;
    @(posedge clk); #1;
    cmd_push = 0;
    if (acc) model(rd, st, rs, d);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || outstanding) @(posedge clk);
    repeat (10) @(posedge clk);
  endtask

  // Bit engine model: done three cycles after each request
  initial begin
    forever begin
      @(posedge clk); #1;
      if (eng_req) begin
        while (stall) begin @(posedge clk); #1; end
        repeat (2) @(posedge clk);
        #1 eng_done = 1;
        @(posedge clk); #1 eng_done = 0;
      end
    end
  end

  // Per-clock monitor against the expected stream
  always @(negedge clk) begin
    if (!rst) begin
      if (eng_done) begin
        outstanding = 0;
        since_done = 0;
        gap_armed = (exp_q.size() > 0);
      end else since_done++;
      if (eng_req) begin
        chk(!outstanding, "R10 overlap", 1, 0);
        if (gap_armed) chk(since_done == 2, "R10 gap", since_done, 2);
        gap_armed = 0;
        outstanding = 1;
        if (exp_q.size() == 0)
          chk(0, "R9 unexpected request", eng_act * 256 + eng_byte, -1);
        else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(eng_act * 256 + eng_byte == e, t, eng_act * 256 + eng_byte, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(eng_req == 0, "R11 req", eng_req, 0);
    chk(scl_hold == 0, "R11 hold", scl_hold, 0);
    chk(cmd_full == 0, "R11 full", cmd_full, 0);

    // R1, R2, R6: three writes, stop on the last
    push(0, 0, 0, 8'h11);
    push(0, 0, 0, 8'h22);
    push(0, 1, 0, 8'h33);
    drain();
    chk(scl_hold == 0, "R7 idle not held", scl_hold, 0);

    // R3 forced restart, R4 direction change, R8 read byte zero
    push(0, 0, 0, 8'h44);
    push(0, 0, 1, 8'h55);
    push(1, 1, 0, 8'hA5);
    drain();

    // R5 restarts disabled: STOP then START
    restart_en = 0;
    push(0, 0, 0, 8'h66);
    push(1, 0, 0, 8'h77);
    push(1, 1, 1, 8'h88);
    drain();
    restart_en = 1;

    // R6 back-to-back stops
    push(0, 1, 0, 8'h99);
    push(0, 1, 0, 8'hAA);
    drain();

    // R7 queue runs dry without stop
    push(0, 0, 0, 8'hBB);
    drain();
    chk(scl_hold == 1, "R7 hold", scl_hold, 1);
    push(0, 0, 0, 8'hCC);
    drain();
    chk(scl_hold == 1, "R7 hold again", scl_hold, 1);
    push(0, 1, 0, 8'hDD);
    drain();
    chk(scl_hold == 0, "R7 released", scl_hold, 0);

    // R9 full queue drops extra push
    stall = 1;
    push(0, 0, 0, 8'h01);
    push(0, 0, 0, 8'h02);
    push(0, 0, 0, 8'h03);
    push(0, 1, 0, 8'h04);
    @(negedge clk);
    chk(cmd_full == 1, "R9 full", cmd_full, 1);
    push(1, 1, 0, 8'h05);
    @(negedge clk);
    chk(cmd_full == 1, "R9 still full", cmd_full, 1);
    stall = 0;
    drain();
    repeat (20) @(posedge clk);
    chk(exp_q.size() == 0, "R9 stream done", exp_q.size(), 0);
    chk(cmd_full == 0, "R9 emptied", cmd_full, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule